// File: doc/BRIEF.md
# Retention Save/Restore Power Sequencer

This block is a hardware sequencer for a single switchable power domain that has retention flip-flops. On a power-up request it removes the clock gate and isolation, releases the domain reset, and then decides whether to restore the retained state. On a power-down request it first saves the retained state, then isolates the domain, gates its clock and asserts its reset. Each of these actions is a single bit of a 32-bit domain control word, and the sequencer changes exactly one bit per clock cycle.

A 2-bit retention type code, captured with the request, selects the save/restore variant: no retention, a generic peripheral, a PCIe PHY, or a storage controller. The PHY variant adds fixed settling waits around isolation changes. Their lengths are given in microseconds and converted to cycles from a clock-frequency parameter. The "saved" flag can also be changed by other masters, so it is an input. Between sequences the sequencer's own copy of the flag follows that input.

Top module: `ret_pwr_seq`

## Requirements
- R1: While `rst` is high and after it is released, `ctl` holds the domain-off word: bit 0 (reset, active low) = 0, bit 1 (isolation) = 1, bit 4 (main clock disable) = 1, bit 25 (restore, active low) = 1, and every other bit = 0. `busy` and `done` are 0.
- R2: A request that arrives while idle raises `busy` on the next edge. After that, each control step changes exactly one `ctl` bit per cycle. On the final edge `busy` falls and `done` is high for exactly one cycle. Retention bits: save = 24, restore (active low) = 25, retention clock disable = 26, saved flag = 27, storage clock disable = 28.
- R3: The power-up order is as follows. For type 2 (PHY), set bit 26 first. Then clear bit 4, then clear bit 1, and then set bit 0.
- R4: For type 2, power-up holds for ceil(PHY_UP_US × CLK_KHZ / 1000) cycles after isolation clears and before reset is released.
- R5: After reset release there is one decision cycle. Types 1 and 2 restore only if `saved_in` is 1. Type 3 always restores. Type 0 never restores. A domain that does not restore finishes on the decision edge.
- R6: The type 1 restore order is: clear bit 27, set bit 26, clear bit 25, set bit 25, clear bit 26.
- R7: The type 2 restore order is: clear bit 27, clear bit 25, set bit 25, clear bit 26.
- R8: The type 3 restore order is: set bit 28, clear bit 25, set bit 25, clear bit 28. Bit 27 is not written.
- R9: For types 1 and 2, power-down first sets bit 26, sets bit 24, clears bit 24, clears bit 26 and then sets bit 27. Type 3 does the same save pulse under bit 28 and does not write bit 27. Type 0 has no save steps.
- R10: After the save steps, power-down sets bit 1. For type 2 it then holds for ceil(PHY_DN_US × CLK_KHZ / 1000) cycles. After that it sets bit 4 and then clears bit 0.
- R11: Requests are ignored while `busy` is high. If `req_on` and `req_off` arrive together while idle, power-up is performed.
- R12: While idle, `ctl` bit 27 takes the value of `saved_in` on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_on | input | 1 | Power-up request, sampled when idle |
| req_off | input | 1 | Power-down request, sampled when idle |
| ret_type | input | 2 | Retention type: 0 none, 1 generic, 2 PHY, 3 storage |
| saved_in | input | 1 | Current saved-flag value from the shared register |
| ctl | output | CTL_W | Domain control word (registered) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench runs each retention type in both directions and restores both with the saved flag clear and with it set. A sequencer that read the flag for the storage type, or ignored it for the generic type, would produce a different step list on the wrong cycle. The PHY waits are measured to the exact cycle, so an off-by-one in the microsecond rounding or in the wait counter shifts every later step. The bench also issues a power-down in the middle of a PHY power-up wait and issues two requests at once. A design that accepted a request while busy would change the control word there.

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;

  localparam int SEQ_IW  = 4;
  localparam int SEQ_LEN = 1 << SEQ_IW;

  localparam int B_RSTN  = 0;
  localparam int B_ISO   = 1;
  localparam int B_CKDIS = 4;
  localparam int B_SAVE  = 24;
  localparam int B_NREST = 25;
  localparam int B_RCLK  = 26;
  localparam int B_FLAG  = 27;
  localparam int B_UCLK  = 28;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_GEN  = 2'd1,
    RT_PHY  = 2'd2,
    RT_STOR = 2'd3
  } rtype_e;

  typedef enum logic [2:0] {
    OP_SET, OP_CLR, OP_WAIT_UP, OP_WAIT_DN, OP_CHECK, OP_END
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [4:0] pos;
  } step_t;

  // Builds the step list for one direction and type, returns entry idx.
  function automatic step_t seq_at(input logic on, input rtype_e rt,
                                   input logic [SEQ_IW-1:0] idx);
    step_t s [SEQ_LEN];
    int    n;
    for (int i = 0; i < SEQ_LEN; i++) s[i] = '{op: OP_END, pos: 5'd0};
    n = 0;
    if (on) begin
      if (rt == RT_PHY) begin s[n] = '{OP_SET, 5'(B_RCLK)}; n++; end
      s[n] = '{OP_CLR, 5'(B_CKDIS)}; n++;
      s[n] = '{OP_CLR, 5'(B_ISO)};   n++;
      if (rt == RT_PHY) begin s[n] = '{OP_WAIT_UP, 5'd0}; n++; end
      s[n] = '{OP_SET, 5'(B_RSTN)};  n++;
      s[n] = '{OP_CHECK, 5'd0};      n++;
      case (rt)
        RT_GEN: begin
          s[n] = '{OP_CLR, 5'(B_FLAG)};  n++;
          s[n] = '{OP_SET, 5'(B_RCLK)};  n++;
          s[n] = '{OP_CLR, 5'(B_NREST)}; n++;
          s[n] = '{OP_SET, 5'(B_NREST)}; n++;
          s[n] = '{OP_CLR, 5'(B_RCLK)};  n++;
        end
        RT_PHY: begin
          s[n] = '{OP_CLR, 5'(B_FLAG)};  n++;
          s[n] = '{OP_CLR, 5'(B_NREST)}; n++;
          s[n] = '{OP_SET, 5'(B_NREST)}; n++;
          s[n] = '{OP_CLR, 5'(B_RCLK)};  n++;
        end
        RT_STOR: begin
          s[n] = '{OP_SET, 5'(B_UCLK)};  n++;
          s[n] = '{OP_CLR, 5'(B_NREST)}; n++;
          s[n] = '{OP_SET, 5'(B_NREST)}; n++;
          s[n] = '{OP_CLR, 5'(B_UCLK)};  n++;
        end
        default: ;
      endcase
    end else begin
      if (rt == RT_GEN || rt == RT_PHY) begin
        s[n] = '{OP_SET, 5'(B_RCLK)}; n++;
        s[n] = '{OP_SET, 5'(B_SAVE)}; n++;
        s[n] = '{OP_CLR, 5'(B_SAVE)}; n++;
        s[n] = '{OP_CLR, 5'(B_RCLK)}; n++;
        s[n] = '{OP_SET, 5'(B_FLAG)}; n++;
      end else if (rt == RT_STOR) begin
        s[n] = '{OP_SET, 5'(B_UCLK)}; n++;
        s[n] = '{OP_SET, 5'(B_SAVE)}; n++;
        s[n] = '{OP_CLR, 5'(B_SAVE)}; n++;
        s[n] = '{OP_CLR, 5'(B_UCLK)}; n++;
      end
      s[n] = '{OP_SET, 5'(B_ISO)}; n++;
      if (rt == RT_PHY) begin s[n] = '{OP_WAIT_DN, 5'd0}; n++; end
      s[n] = '{OP_SET, 5'(B_CKDIS)}; n++;
      s[n] = '{OP_CLR, 5'(B_RSTN)};  n++;
    end
    return s[idx];
  endfunction

endpackage

// File: rtl/rps_step_rom.sv
`timescale 1ns/1ps
module rps_step_rom
  import rps_pkg::*;
(
  input  logic              dir_on,
  input  rtype_e            rt,
  input  logic [SEQ_IW-1:0] idx,
  output step_t             step
);
  assign step = seq_at(dir_on, rt, idx);
endmodule

// File: rtl/rps_wait_timer.sv
`timescale 1ns/1ps
module rps_wait_timer #(
  parameter int UP_CYC = 1000,
  parameter int DN_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic sel_dn,
  output logic expire
);
  localparam int MAXC = (UP_CYC > DN_CYC) ? UP_CYC : DN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] UP_LAST = CW'(UP_CYC - 1);
  localparam logic [CW-1:0] DN_LAST = CW'(DN_CYC - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == (sel_dn ? DN_LAST : UP_LAST));

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rps_ctl_bank.sv
`timescale 1ns/1ps
module rps_ctl_bank
  import rps_pkg::*;
#(
  parameter int CTL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [4:0]       pos,
  input  logic             val,
  input  logic             track,
  input  logic             saved_in,
  output logic [CTL_W-1:0] ctl
);
  localparam logic [CTL_W-1:0] OFF_WORD =
      (CTL_W'(1) << B_ISO) | (CTL_W'(1) << B_CKDIS) | (CTL_W'(1) << B_NREST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= OFF_WORD;
    end else begin
      if (track) ctl[B_FLAG] <= saved_in;
      if (wr)    ctl[pos]    <= val;
    end
  end
endmodule

// File: rtl/ret_pwr_seq.sv
`timescale 1ns/1ps
module ret_pwr_seq
  import rps_pkg::*;
#(
  parameter int CTL_W      = 32,
  parameter int CLK_KHZ    = 200000,
  parameter int PHY_UP_US  = 5,
  parameter int PHY_DN_US  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_on,
  input  logic             req_off,
  input  logic [1:0]       ret_type,
  input  logic             saved_in,
  output logic [CTL_W-1:0] ctl,
  output logic             busy,
  output logic             done
);
  localparam int UP_RAW = (PHY_UP_US * CLK_KHZ + 999) / 1000;
  localparam int DN_RAW = (PHY_DN_US * CLK_KHZ + 999) / 1000;
  localparam int UP_CYC = (UP_RAW < 1) ? 1 : UP_RAW;
  localparam int DN_CYC = (DN_RAW < 1) ? 1 : DN_RAW;

  logic              dir_on;
  rtype_e            rt_q;
  logic [SEQ_IW-1:0] idx;
  step_t             step;
  logic              expire;
  logic              in_wait;
  logic              do_restore;

  rps_step_rom u_rom (.dir_on(dir_on), .rt(rt_q), .idx(idx), .step(step));

  assign in_wait = busy && (step.op == OP_WAIT_UP || step.op == OP_WAIT_DN);

  rps_wait_timer #(.UP_CYC(UP_CYC), .DN_CYC(DN_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run(in_wait),
    .sel_dn(step.op == OP_WAIT_DN), .expire(expire)
  );

  rps_ctl_bank #(.CTL_W(CTL_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr(busy && (step.op == OP_SET || step.op == OP_CLR)),
    .pos(step.pos), .val(step.op == OP_SET),
    .track(!busy), .saved_in(saved_in), .ctl(ctl)
  );

  always_comb begin
    case (rt_q)
      RT_GEN, RT_PHY: do_restore = saved_in;
      RT_STOR:        do_restore = 1'b1;
      default:        do_restore = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      dir_on <= 1'b0;
      rt_q   <= RT_NONE;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_on || req_off) begin
          busy   <= 1'b1;
          dir_on <= req_on;
          rt_q   <= rtype_e'(ret_type);
          idx    <= '0;
        end
      end else begin
        case (step.op)
          OP_END: begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          OP_WAIT_UP, OP_WAIT_DN: if (expire) idx <= idx + 1'b1;
          OP_CHECK: begin
            if (do_restore) idx <= idx + 1'b1;
            else begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
          default: idx <= idx + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/ret_pwr_seq_chk.sv
`timescale 1ns/1ps
module ret_pwr_seq_chk
  import rps_pkg::*;
#(
  parameter int CTL_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             saved_in,
  input logic [CTL_W-1:0] ctl,
  input logic             busy,
  input logic             done
);
  p_reset_word_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctl[B_ISO] && ctl[B_CKDIS] && !ctl[B_RSTN] && ctl[B_NREST] && !busy));

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_end_with_done_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_rst_after_iso_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl[B_RSTN]) |-> !ctl[B_ISO] && !ctl[B_CKDIS]);

  p_restore_gated_r6: assert property (@(posedge clk) disable iff (rst)
    !ctl[B_NREST] |-> (ctl[B_RCLK] || ctl[B_UCLK]));

  p_save_gated_r9: assert property (@(posedge clk) disable iff (rst)
    ctl[B_SAVE] |-> (ctl[B_RCLK] || ctl[B_UCLK]));

  p_iso_first_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl[B_ISO]) |-> ctl[B_RSTN] && !ctl[B_CKDIS]);

  p_flag_track_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(busy) && !$past(rst)) |-> (ctl[B_FLAG] == $past(saved_in)));
endmodule

bind ret_pwr_seq ret_pwr_seq_chk #(.CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst(rst), .saved_in(saved_in), .ctl(ctl), .busy(busy), .done(done)
);

// File: tb/tb_ret_pwr_seq.sv
`timescale 1ns/1ps
module tb_ret_pwr_seq;
  localparam int N_UP = 1000;  // 5 us at 200 MHz
  localparam int N_DN = 200;   // 1 us at 200 MHz
  localparam logic [31:0] OFFW = 32'h0200_0012;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_on = 1'b0, req_off = 1'b0, saved_in = 1'b0;
  logic [1:0] ret_type = 2'd0;
  logic [31:0] ctl;
  logic busy, done;

  always #2.5 clk = ~clk;

  ret_pwr_seq dut (.clk(clk), .rst(rst), .req_on(req_on), .req_off(req_off),
    .ret_type(ret_type), .saved_in(saved_in), .ctl(ctl), .busy(busy), .done(done));

  typedef struct packed { logic [31:0] c; logic b; logic d; } ent_t;
  ent_t  q[$];
  string tq[$];
  logic [31:0] m_ctl = OFFW;
  logic m_b = 1'b0, m_d = 1'b0;
  string tag = "R1";
  int checks = 0, fails = 0;
  bit fin = 0;

  task automatic push(input logic [31:0] c, input logic b, input logic d, input string t);
    q.push_back('{c: c, b: b, d: d});
    tq.push_back(t);
  endtask

  task automatic build(input logic on, input int rt, input logic sv, input string t0);
    logic [31:0] c;
    bit rest;
    c = m_ctl; c[27] = sv;
    push(c, 1, 0, t0);
    if (on) begin
      if (rt == 2) begin c[26] = 1; push(c, 1, 0, "R3"); end
      c[4] = 0; push(c, 1, 0, "R3");
      c[1] = 0; push(c, 1, 0, "R3");
      if (rt == 2) for (int i = 0; i < N_UP; i++) push(c, 1, 0, "R4");
      c[0] = 1; push(c, 1, 0, "R3");
      rest = (rt == 3) || ((rt == 1 || rt == 2) && sv);
      if (!rest) begin push(c, 0, 1, "R5"); return; end
      push(c, 1, 0, "R5");
      if (rt == 1) begin
        c[27] = 0; push(c, 1, 0, "R6"); c[26] = 1; push(c, 1, 0, "R6");
        c[25] = 0; push(c, 1, 0, "R6"); c[25] = 1; push(c, 1, 0, "R6");
        c[26] = 0; push(c, 1, 0, "R6");
      end else if (rt == 2) begin
        c[27] = 0; push(c, 1, 0, "R7"); c[25] = 0; push(c, 1, 0, "R7");
        c[25] = 1; push(c, 1, 0, "R7"); c[26] = 0; push(c, 1, 0, "R7");
      end else begin
        c[28] = 1; push(c, 1, 0, "R8"); c[25] = 0; push(c, 1, 0, "R8");
        c[25] = 1; push(c, 1, 0, "R8"); c[28] = 0; push(c, 1, 0, "R8");
      end
      push(c, 0, 1, "R2");
    end else begin
      if (rt == 1 || rt == 2) begin
        c[26] = 1; push(c, 1, 0, "R9"); c[24] = 1; push(c, 1, 0, "R9");
        c[24] = 0; push(c, 1, 0, "R9"); c[26] = 0; push(c, 1, 0, "R9");
        c[27] = 1; push(c, 1, 0, "R9");
      end else if (rt == 3) begin
        c[28] = 1; push(c, 1, 0, "R9"); c[24] = 1; push(c, 1, 0, "R9");
        c[24] = 0; push(c, 1, 0, "R9"); c[28] = 0; push(c, 1, 0, "R9");
      end
      c[1] = 1; push(c, 1, 0, "R10");
      if (rt == 2) for (int i = 0; i < N_DN; i++) push(c, 1, 0, "R10");
      c[4] = 1; push(c, 1, 0, "R10");
      c[0] = 0; push(c, 1, 0, "R10");
      push(c, 0, 1, "R2");
    end
  endtask

  // Reference model steps on the negedge following each active edge, then compares.
  always @(negedge clk) begin
    ent_t e;
    if (rst) begin
      q.delete(); tq.delete();
      m_ctl = OFFW; m_b = 0; m_d = 0; tag = "R1";
    end else if (q.size() > 0) begin
      e = q.pop_front(); tag = tq.pop_front();
      if (req_on || req_off) tag = "R11";  // request while busy must be ignored
      m_ctl = e.c; m_b = e.b; m_d = e.d;
    end else begin
      m_b = 0; m_d = 0; m_ctl[27] = saved_in; tag = "R12";
      if (req_on || req_off) begin
        build(req_on, int'(ret_type), saved_in, (req_on && req_off) ? "R11" : "R2");
        e = q.pop_front(); tag = tq.pop_front();
        m_ctl = e.c; m_b = e.b; m_d = e.d;
      end
    end
    checks++;
    if (ctl !== m_ctl || busy !== m_b || done !== m_d) begin
      fails++;
      $display("FAIL %s at %0t: ctl=%h busy=%b done=%b expected ctl=%h busy=%b done=%b",
               tag, $time, ctl, busy, done, m_ctl, m_b, m_d);
    end
  end

  task automatic run(input logic on, input logic off, input logic [1:0] rt);
    @(negedge clk); #1;
    req_on = on; req_off = off; ret_type = rt;
    @(negedge clk); #1;
    req_on = 0; req_off = 0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;                               // R1 checked each cycle
    repeat (3) @(negedge clk);
    #1 saved_in = 1; repeat (3) @(negedge clk);  // R12 idle tracking
    #1 saved_in = 0; repeat (2) @(negedge clk);
    #1;
    run(1, 0, 2'd0); run(0, 1, 2'd0);         // type none
    run(1, 0, 2'd1);                          // R5 generic without flag
    run(0, 1, 2'd1);                          // R9 generic save
    saved_in = 1; run(1, 0, 2'd1);            // R6 generic restore
    run(0, 1, 2'd2);                          // R10 PHY wait
    saved_in = 1;
    @(negedge clk); #1;                       // R11 request during PHY wait
    req_on = 1; ret_type = 2'd2;
    @(negedge clk); #1; req_on = 0;
    repeat (40) @(negedge clk);
    #1 req_off = 1; ret_type = 2'd1;
    @(negedge clk); #1 req_off = 0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk); #1;
    run(0, 1, 2'd2);
    saved_in = 0; run(1, 0, 2'd2);            // R5 PHY without flag, R4 wait
    run(0, 1, 2'd3);                          // R9 storage save
    saved_in = 0; run(1, 0, 2'd3);            // R8 storage restores regardless
    run(1, 1, 2'd0);                          // R11 power-up wins
    run(0, 1, 2'd0);
    repeat (3) @(negedge clk);
    fin = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule